// File: doc/BRIEF.md
# Parallel RGB Panel Output Formatter

This block takes a pixel stream from an upstream display timing generator (one 24-bit RGB pixel, a horizontal sync, a vertical sync and a data-enable on every pixel clock) and turns it into the pin-level signals of a parallel RGB panel. The three colour channels can be swapped around. The result is then placed onto 24 data lines in one of several padded 16, 18 or 24 bit layouts. The sync and enable pins each have their own polarity, launch edge and disable settings, and the enable pin can carry a composite sync instead of data-enable.

Software reaches the block through a small 32-bit register port. One control word at offset 0 holds all settings. Every other offset reads back a fixed identification constant. Settings written while the block runs are held back until the next frame begins, so no frame is shown half in the old setup and half in the new. The pixel input has no ready signal and no valid qualifier. A panel cannot stall, so the block takes a pixel on every rising clock edge and never applies back-pressure. Software turns the whole output off by clearing the run bit, and setting that bit again starts from a clean pipeline.

Top module: `rgb_panel_fmt`

## Requirements
- R1: Offset 0 is read/write for bits [16:0]; bits [31:17] read as zero. A read of any nonzero offset returns 0x00647069. A write to a nonzero offset changes nothing. The control word resets to zero.
- R2: Bit 0 is the run bit and acts at once, with no wait for a frame boundary. While it reads 0, `pix_o`, `hsync_o`, `vsync_o` and `oe_o` are zero from the next rising edge on, and `pclk_o` is zero.
- R3: Bits [15:14] reorder the input channels (red in [23:16], green in [15:8], blue in [7:0]) before packing. The codes give the channel order from top to bottom: 0 = R,G,B; 1 = B,G,R; 2 = G,R,B; 3 = B,R,G.
- R4: Bits [13:11] pick the line layout for the reordered channels A,B,C. Each reduced channel keeps its top bits. The layouts, from line 23 down, are:
  - code 1: 8 zeros, A5, B6, C5.
  - code 2: 3 zeros, A5, 2 zeros, B6, 3 zeros, C5.
  - code 3: 2 zeros, A5, 3 zeros, B6, 2 zeros, C5, 1 zero.
  - code 4: 6 zeros, A6, B6, C6.
  - code 5: 2 zeros, A6, 2 zeros, B6, 2 zeros, C6.
  - code 6: A8, B8, C8.
  - codes 0 and 7: all zeros.
- R5: The data lines change on the rising edge after the pixel is presented, with exactly one register stage of latency.
- R6: The inversion bits are bit 10 for `pclk_o`, bit 9 for hsync, bit 8 for vsync and bit 7 for the enable pin. With no inversion, `pclk_o` follows `clk`, and each control output is active-high.
- R7: Bits 6, 5 and 4 make hsync, vsync and the enable pin, in that order, launch on the falling clock edge, half a cycle after the rising-edge timing.
- R8: Bits 3, 2 and 1 disable hsync, vsync and the enable pin, in that order. A disabled pin rests at its inactive level, which is 0, or 1 when that pin's inversion bit is set.
- R9: Bit 16 set routes data-enable to `oe_o`. Bit 16 clear routes the composite sync, `hsync_i` XOR `vsync_i`, to `oe_o`, and `de_i` is ignored. Bit 7 inverts either source.
- R10: While running, a change to bits [16:1] takes effect with the first cycle in which `vsync_i` is high after being low, and applies to that very pixel. Until then the old settings stay in force.
- R11: A 0-to-1 change of the run bit clears the pipeline and applies the full control word at once, with no wait for a vsync edge. Nothing from before the stop reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| pix_i | input | 24 | Input pixel, red in [23:16], green in [15:8], blue in [7:0] |
| hsync_i | input | 1 | Active-high horizontal sync |
| vsync_i | input | 1 | Active-high vertical sync |
| de_i | input | 1 | Active-high data-enable |
| pix_o | output | 24 | Packed panel data lines |
| hsync_o | output | 1 | Panel horizontal sync |
| vsync_o | output | 1 | Panel vertical sync |
| oe_o | output | 1 | Panel enable pin (data-enable or composite sync) |
| pclk_o | output | 1 | Panel pixel clock, optionally inverted |

## Verification
The bench builds the block with the default `ADDR_W` of 4, so every offset from 0x0 to 0xF can be reached. Reads at 0x4 and 0xC, and a write at 0x4 that must leave the control word alone, cover the identification path and the write decode. With this width, the full 17-bit control word and every packing code are driven directly. Mid-clock sampling separates the falling-edge launch from the rising-edge launch and shows the level of the inverted pixel clock.

// File: rtl/rgb_panel_fmt_pkg.sv
package rgb_panel_fmt_pkg;

  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;
  localparam int CTL_W = 17;

  // Field positions follow the control word bit map (bit 16 down to bit 0).
  typedef struct packed {
    logic       oe_de_mode;
    logic [1:0] order;
    logic [2:0] layout;
    logic       clk_inv;
    logic       hs_inv;
    logic       vs_inv;
    logic       oe_inv;
    logic       hs_fall;
    logic       vs_fall;
    logic       oe_fall;
    logic       hs_off;
    logic       vs_off;
    logic       oe_off;
    logic       run;
  } ctrl_t;

  function automatic logic [PIX_W-1:0] shuffle(input logic [1:0] code, input logic [PIX_W-1:0] px);
    logic [CH_W-1:0] r, g, b;
    r = px[3*CH_W-1:2*CH_W];
    g = px[2*CH_W-1:CH_W];
    b = px[CH_W-1:0];
    case (code)
      2'd0: shuffle = {r, g, b};
      2'd1: shuffle = {b, g, r};
      2'd2: shuffle = {g, r, b};
      default: shuffle = {b, r, g};
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] pack_lines(input logic [2:0] code, input logic [PIX_W-1:0] px);
    logic [CH_W-1:0] a, m, c;
    a = px[3*CH_W-1:2*CH_W];
    m = px[2*CH_W-1:CH_W];
    c = px[CH_W-1:0];
    case (code)
      3'd1: pack_lines = {8'b0, a[7:3], m[7:2], c[7:3]};
      3'd2: pack_lines = {3'b0, a[7:3], 2'b0, m[7:2], 3'b0, c[7:3]};
      3'd3: pack_lines = {2'b0, a[7:3], 3'b0, m[7:2], 2'b0, c[7:3], 1'b0};
      3'd4: pack_lines = {6'b0, a[7:2], m[7:2], c[7:2]};
      3'd5: pack_lines = {2'b0, a[7:2], 2'b0, m[7:2], 2'b0, c[7:2]};
      3'd6: pack_lines = {a, m, c};
      default: pack_lines = '0;
    endcase
  endfunction

endpackage

// File: rtl/rgb_panel_fmt_regs.sv
module rgb_panel_fmt_regs
  import rgb_panel_fmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  wdata,
  output ctrl_t             ctl_q,
  output logic [31:0]       rdata
);

  logic hit_ctl;
  assign hit_ctl = (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctl_q <= '0;
    else if (we && hit_ctl)  ctl_q <= ctrl_t'(wdata);
  end

  assign rdata = hit_ctl ? {{(32-CTL_W){1'b0}}, ctl_q} : ID_VALUE;

endmodule

// File: rtl/rgb_panel_fmt_cfg.sv
module rgb_panel_fmt_cfg
  import rgb_panel_fmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t reg_cfg,
  input  logic  vsync_i,
  output ctrl_t use_cfg,
  output logic  frame_load
);

  ctrl_t held_q;
  logic  vs_prev_q;
  logic  run_prev_q;

  // Load on the first running cycle and on each vsync rising edge.
  assign frame_load = reg_cfg.run && (!run_prev_q || (vsync_i && !vs_prev_q));

  always_comb begin
    use_cfg     = (frame_load || !reg_cfg.run) ? reg_cfg : held_q;
    use_cfg.run = reg_cfg.run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= '0;
      vs_prev_q  <= 1'b0;
      run_prev_q <= 1'b0;
    end else begin
      run_prev_q <= reg_cfg.run;
      if (!reg_cfg.run) begin
        vs_prev_q <= 1'b0;
        held_q    <= reg_cfg;
      end else begin
        vs_prev_q <= vsync_i;
        held_q    <= use_cfg;
      end
    end
  end

endmodule

// File: rtl/rgb_panel_fmt_lane.sv
module rgb_panel_fmt_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic raw,
  input  logic inv,
  input  logic fall,
  input  logic off,
  output logic pin
);

  logic rise_q;
  logic fall_q;
  logic sel_fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q     <= 1'b0;
      sel_fall_q <= 1'b0;
    end else begin
      rise_q     <= run ? (off ? inv : (raw ^ inv)) : 1'b0;
      sel_fall_q <= run & fall;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign pin = sel_fall_q ? fall_q : rise_q;

endmodule

// File: rtl/rgb_panel_fmt.sv
module rgb_panel_fmt
  import rgb_panel_fmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              de_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              oe_o,
  output logic              pclk_o
);

  localparam int N_LANES = 3;

  ctrl_t ctl_q;
  ctrl_t use_cfg;
  logic  frame_load;

  rgb_panel_fmt_regs #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata[CTL_W-1:0]),
    .ctl_q (ctl_q),
    .rdata (reg_rdata)
  );

  rgb_panel_fmt_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_cfg    (ctl_q),
    .vsync_i    (vsync_i),
    .use_cfg    (use_cfg),
    .frame_load (frame_load)
  );

  logic [PIX_W-1:0] pix_q;
  logic             pclk_inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q      <= '0;
      pclk_inv_q <= 1'b0;
    end else begin
      pclk_inv_q <= use_cfg.clk_inv;
      if (!ctl_q.run) pix_q <= '0;
      else            pix_q <= pack_lines(use_cfg.layout, shuffle(use_cfg.order, pix_i));
    end
  end

  assign pix_o  = pix_q;
  assign pclk_o = ctl_q.run & (clk ^ pclk_inv_q);

  // Lane 2 = hsync, lane 1 = vsync, lane 0 = enable pin.
  logic oe_src;
  assign oe_src = use_cfg.oe_de_mode ? de_i : (hsync_i ^ vsync_i);

  logic [N_LANES-1:0] l_raw, l_inv, l_fall, l_off, l_pin;
  assign l_raw  = {hsync_i, vsync_i, oe_src};
  assign l_inv  = {use_cfg.hs_inv,  use_cfg.vs_inv,  use_cfg.oe_inv};
  assign l_fall = {use_cfg.hs_fall, use_cfg.vs_fall, use_cfg.oe_fall};
  assign l_off  = {use_cfg.hs_off,  use_cfg.vs_off,  use_cfg.oe_off};

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    rgb_panel_fmt_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl_q.run),
      .raw   (l_raw[i]),
      .inv   (l_inv[i]),
      .fall  (l_fall[i]),
      .off   (l_off[i]),
      .pin   (l_pin[i])
    );
  end

  assign hsync_o = l_pin[2];
  assign vsync_o = l_pin[1];
  assign oe_o    = l_pin[0];

endmodule

// File: rtl/rgb_panel_fmt_chk.sv
module rgb_panel_fmt_chk
  import rgb_panel_fmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [PIX_W-1:0]  pix_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic [PIX_W-1:0]  pix_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              oe_o,
  input ctrl_t             ctl_q,
  input ctrl_t             use_cfg,
  input logic              frame_load
);

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != '0) |-> (reg_rdata == ID_VALUE)); // R1

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.run |=> (pix_o == '0 && !hsync_o && !vsync_o && !oe_o)); // R2

  AST_PASS_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && use_cfg.layout == 3'd6 && use_cfg.order == 2'd0) |=> (pix_o == $past(pix_i))); // R5

  AST_HS_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && use_cfg.hs_off && !use_cfg.hs_fall) |=> (hsync_o == $past(use_cfg.hs_inv))); // R8

  AST_CSYNC_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && !use_cfg.oe_de_mode && !use_cfg.oe_off && !use_cfg.oe_fall)
      |=> (oe_o == $past(hsync_i ^ vsync_i ^ use_cfg.oe_inv))); // R9

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_q.run) && ctl_q.run && !frame_load) |-> (use_cfg == $past(use_cfg))); // R10

endmodule

bind rgb_panel_fmt rgb_panel_fmt_chk #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .pix_i      (pix_i),
  .hsync_i    (hsync_i),
  .vsync_i    (vsync_i),
  .pix_o      (pix_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .oe_o       (oe_o),
  .ctl_q      (ctl_q),
  .use_cfg    (use_cfg),
  .frame_load (frame_load)
);

// File: tb/rgb_panel_fmt_tb.sv
`timescale 1ns/1ps
module rgb_panel_fmt_tb_top;

  localparam int ADDR_W = 4;
  localparam logic [31:0] ID = 32'h0064_7069;

  localparam int RUN = 1, OE_OFF = 2, VS_OFF = 4, HS_OFF = 8;
  localparam int OE_FALL = 16, VS_FALL = 32, HS_FALL = 64;
  localparam int OE_INV = 128, VS_INV = 256, HS_INV = 512, CK_INV = 1024;
  localparam int DE_MODE = 32'h1_0000;
  localparam int L888 = 6 << 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] pix_i = '0;
  logic hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [23:0] pix_o;
  logic hsync_o, vsync_o, oe_o, pclk_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rgb_panel_fmt #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_i(pix_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i), .pix_o(pix_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .oe_o(oe_o), .pclk_o(pclk_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    reg_addr = '0;
  endtask

  // Drive at the falling edge, return 1 ns after the next rising edge.
  task automatic step(input logic [23:0] p, input logic hs, input logic vs, input logic de);
    @(negedge clk);
    pix_i = p; hsync_i = hs; vsync_i = vs; de_i = de;
    @(posedge clk); #1;
  endtask

  task automatic restart(input int cfg);
    wr('0, 32'h0);
    wr('0, cfg | RUN);
  endtask

  task automatic t_reset;
    chk(pix_o == 0 && !hsync_o && !vsync_o && !oe_o && !pclk_o, "R2 reset outputs", {pix_o, 8'h0}, 0);
    rd(4'h0, 32'h0, "R1 control reset");
    rd(4'h4, ID, "R1 id at 0x4");
  endtask

  task automatic t_regs;
    wr(4'h0, 32'hFFFE_0000 | 32'h0001_FFFE);
    rd(4'h0, 32'h0001_FFFE, "R1 writable bits");
    wr(4'h4, 32'h0000_1234);
    rd(4'h0, 32'h0001_FFFE, "R1 write at 0x4 ignored");
    rd(4'hC, ID, "R1 id at 0xC");
    wr(4'h0, 32'h0);
  endtask

  task automatic t_order;
    logic [23:0] exp [4] = '{24'hC3A55A, 24'h5AA5C3, 24'hA5C35A, 24'h5AC3A5};
    for (int k = 0; k < 4; k++) begin
      restart(L888 | (k << 14) | DE_MODE);
      step(24'hC3A55A, 0, 0, 1);
      chk(pix_o == exp[k], "R3 channel order", pix_o, exp[k]);
    end
  endtask

  task automatic pk(input int code, input logic [23:0] p, input logic [23:0] exp);
    restart((code << 11) | DE_MODE);
    step(p, 0, 0, 1);
    chk(pix_o == exp, $sformatf("R4 layout %0d", code), pix_o, exp);
  endtask

  task automatic t_pack;
    pk(0, 24'hC3A55A, 24'h000000);
    pk(1, 24'hC3A55A, 24'h00C52B);
    pk(2, 24'hC3A55A, 24'h18290B);
    pk(3, 24'hC3A55A, 24'h302916);
    pk(3, 24'hFFFFFF, 24'h3E3F3E);
    pk(4, 24'hC3A55A, 24'h030A56);
    pk(5, 24'hFFFFFF, 24'h3F3F3F);
    pk(6, 24'hC3A55A, 24'hC3A55A);
    pk(7, 24'hFFFFFF, 24'h000000);
  endtask

  task automatic t_latency;
    restart(L888 | DE_MODE);
    step(24'h112233, 0, 0, 1);
    @(negedge clk);
    pix_i = 24'h445566;
    #1;
    chk(pix_o == 24'h112233, "R5 old pixel before edge", pix_o, 24'h112233);
    @(posedge clk); #1;
    chk(pix_o == 24'h445566, "R5 new pixel after one edge", pix_o, 24'h445566);
  endtask

  task automatic t_polarity;
    restart(L888 | DE_MODE);
    step(0, 1, 0, 1);
    chk(hsync_o && !vsync_o && oe_o, "R6 plain polarity", {hsync_o, vsync_o, oe_o}, 3'b101);
    chk(pclk_o == 1'b1, "R6 pclk follows clk", pclk_o, 1);
    restart(L888 | DE_MODE | HS_INV | VS_INV | OE_INV | CK_INV);
    step(0, 1, 0, 1);
    step(0, 1, 0, 1);
    chk(!hsync_o && vsync_o && !oe_o, "R6 inverted polarity", {hsync_o, vsync_o, oe_o}, 3'b010);
    chk(pclk_o == 1'b0, "R6 pclk inverted", pclk_o, 0);
  endtask

  task automatic t_fall;
    restart(L888 | DE_MODE | HS_FALL);
    step(0, 0, 0, 0);
    step(0, 1, 1, 1);
    chk(!hsync_o && vsync_o && oe_o, "R7 hsync not yet launched", {hsync_o, vsync_o, oe_o}, 3'b011);
    #2;
    chk(hsync_o == 1'b1, "R7 hsync after falling edge", hsync_o, 1);
  endtask

  task automatic t_off;
    restart(L888 | DE_MODE | HS_OFF | HS_INV | VS_OFF | OE_OFF);
    step(0, 1, 1, 1);
    chk(hsync_o && !vsync_o && !oe_o, "R8 disabled at rest level", {hsync_o, vsync_o, oe_o}, 3'b100);
    step(0, 0, 0, 0);
    chk(hsync_o && !vsync_o && !oe_o, "R8 disabled pins ignore input", {hsync_o, vsync_o, oe_o}, 3'b100);
  endtask

  task automatic t_csync;
    restart(L888);
    step(0, 1, 0, 0);
    chk(oe_o == 1'b1, "R9 csync hs only", oe_o, 1);
    step(0, 1, 1, 1);
    chk(oe_o == 1'b0, "R9 csync both, de ignored", oe_o, 0);
    restart(L888 | OE_INV);
    step(0, 0, 1, 0);
    chk(oe_o == 1'b0, "R9 csync inverted", oe_o, 0);
  endtask

  task automatic t_frame;
    restart(L888 | DE_MODE);
    step(24'hC3A55A, 0, 0, 1);
    wr(4'h0, L888 | DE_MODE | (1 << 14) | RUN);
    step(24'hC3A55A, 0, 0, 1);
    chk(pix_o == 24'hC3A55A, "R10 change held mid-frame", pix_o, 24'hC3A55A);
    step(24'hC3A55A, 0, 1, 1);
    chk(pix_o == 24'h5AA5C3, "R10 change applied at vsync rise", pix_o, 24'h5AA5C3);
    wr(4'h0, L888 | DE_MODE | (1 << 14));
    step(24'hC3A55A, 0, 1, 1);
    chk(pix_o == 0 && !vsync_o && !oe_o, "R2 stop acts at once", pix_o, 0);
  endtask

  task automatic t_restart;
    wr(4'h0, 32'h0);
    step(24'hFFFFFF, 1, 1, 1);
    step(24'hFFFFFF, 1, 1, 1);
    chk(pix_o == 0 && !hsync_o, "R2 outputs held while stopped", pix_o, 0);
    wr(4'h0, L888 | DE_MODE | (2 << 14) | RUN);
    step(24'hC3A55A, 1, 1, 1);
    chk(pix_o == 24'hA5C35A, "R11 word applied on start without vsync edge", pix_o, 24'hA5C35A);
    chk(hsync_o && vsync_o && oe_o, "R11 controls fresh after start", {hsync_o, vsync_o, oe_o}, 3'b111);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_regs();
    t_order();
    t_pack();
    t_latency();
    t_polarity();
    t_fall();
    t_off();
    t_csync();
    t_frame();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule